// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog that counts time-base ticks against one of four power-of-two periods and escalates each time a period runs out without software having cleared its status. The first expiry raises a warning flag. The second raises an interrupt flag, which drives a level interrupt when enabled. The third ends the sequence. At that point the configured reset kind is copied into the status word and, unless that kind is "none", a single-cycle reset request is sent. The counter then stops for good.

Software keeps the watchdog quiet by rewriting the status bits. Writing the two escalation flags back to zero returns the block to its idle stage. The control fields (period select, reset kind and interrupt enable) arrive as plain inputs from a register kept elsewhere. Carrying out the reset itself is left to the logic that consumes the request.

Top module: `wdog_escalator`

## Requirements
- R1: While `rst_n` is low and after it is released, `sts_warn`, `sts_irqf`, `rst_type`, `irq` and `rst_req` are all 0, and the tick counter is 0.
- R2: On an expiry while `sts_warn` is 0, `sts_warn` becomes 1 on that clock edge and the counter restarts from 0. This holds whatever the value of `sts_irqf`.
- R3: On an expiry while `sts_warn` is 1 and `sts_irqf` is 0, `sts_irqf` becomes 1 and the counter restarts from 0.
- R4: On an expiry while both flags are 1, `rst_type` is loaded from `rst_ctl`. The codes are 00 none, 01 core, 10 chip and 11 system.
- R5: `rst_req` is high for exactly one cycle, in the cycle after an R4 expiry, when `rst_ctl` was non-zero at that expiry. It stays low when `rst_ctl` was 00.
- R6: `irq` is a level equal to `sts_irqf` AND `irq_en`.
- R7: After an R4 expiry the counter never expires again until `rst_n` is asserted. This holds whatever reset kind was chosen.
- R8: The counter advances only on cycles with `tick` high. An expiry occurs on the tick that completes 2^(BASE_LOG+STEP_LOG*per_sel) ticks, with `per_sel` read at that tick. With the defaults, codes 0, 1, 2 and 3 give 2^17, 2^21, 2^25 and 2^29 ticks.
- R9: A status write (`sts_wr` high) loads `sts_wdata`, with bit 3 going to `sts_warn`, bit 2 to `sts_irqf` and bits 1:0 to `rst_type`. In that same cycle the write takes precedence over any expiry update of the status. The counter still restarts or stops according to the stage held before the write.
- R10: If `per_sel` is lowered so that the count already reaches or passes the new period's last value, the next tick is an expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base tick enable |
| per_sel | input | 2 | Period select code |
| rst_ctl | input | 2 | Reset kind requested at final stage |
| irq_en | input | 1 | Interrupt enable |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 4 | Status write data: {warn, irqf, rtype[1:0]} |
| sts_warn | output | 1 | Warning flag |
| sts_irqf | output | 1 | Interrupt-stage flag |
| rst_type | output | 2 | Latched reset kind |
| irq | output | 1 | Level interrupt |
| rst_req | output | 1 | One-cycle reset request |

## Verification
A corrupted tick count shows up as a misplaced escalation. The next flag rises early or late by the size of the error, so the fault is visible within one period. A wrong stage encoding sets the wrong flag at the very next expiry, or releases a reset request a full period too early. A halt latch that fails to hold lets a fourth expiry through after the final stage, which shows up as a second `rst_req` pulse one period later. The reference model is compared against every output on every clock, so any of these faults is caught on the first cycle in which it reaches a port.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef struct packed {
    logic       warn;
    logic       irqf;
    logic [1:0] rtype;
  } wd_status_t;

  typedef enum logic [1:0] {
    STG_IDLE  = 2'b00,
    STG_IRQF  = 2'b01,
    STG_WARN  = 2'b10,
    STG_FINAL = 2'b11
  } wd_stage_e;

  function automatic int unsigned period_log2(input logic [1:0] sel,
                                              input int unsigned base_log,
                                              input int unsigned step_log);
    return base_log + step_log * int'(sel);
  endfunction

  function automatic wd_status_t unpack_status(input logic [3:0] raw);
    wd_status_t s;
    s.warn  = raw[3];
    s.irqf  = raw[2];
    s.rtype = raw[1:0];
    return s;
  endfunction

endpackage

// File: rtl/wdog_period_ctr.sv
module wdog_period_ctr #(
  parameter int unsigned BASE_LOG = 17,
  parameter int unsigned STEP_LOG = 4,
  localparam int unsigned CW = BASE_LOG + 3 * STEP_LOG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          halt,
  input  logic [1:0]    per_sel,
  output logic          expire,
  output logic [CW-1:0] cnt
);
  import wdog_pkg::*;

  function automatic logic [CW-1:0] last_count(input logic [1:0] sel);
    logic [CW:0] one;
    one = {{CW{1'b0}}, 1'b1} << period_log2(sel, BASE_LOG, STEP_LOG);
    return CW'(one - 1'b1);
  endfunction

  logic [CW-1:0] last_val;
  logic          reached;

  assign last_val = last_count(per_sel);
  assign reached  = (cnt >= last_val);
  assign expire   = tick && !halt && reached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (tick && !halt) begin
      cnt <= reached ? '0 : cnt + 1'b1;
    end
  end

  p_frozen_when_halted_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> $stable(cnt));

  p_restart_after_expire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> cnt == '0);

  p_idle_without_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

endmodule

// File: rtl/wdog_stage_fsm.sv
module wdog_stage_fsm (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 expire,
  input  logic [1:0]           rst_ctl,
  input  logic                 sts_wr,
  input  logic [3:0]           sts_wdata,
  output wdog_pkg::wd_status_t status,
  output logic                 halt,
  output logic                 rst_req
);
  import wdog_pkg::*;

  wd_stage_e  stage;
  wd_status_t status_nx;
  logic       final_hit;
  logic       req_nx;

  assign stage     = wd_stage_e'({status.warn, status.irqf});
  assign final_hit = expire && (stage == STG_FINAL);
  assign req_nx    = final_hit && (rst_ctl != 2'b00);

  always_comb begin
    status_nx = status;
    if (expire) begin
      unique case (stage)
        STG_IDLE, STG_IRQF: status_nx.warn  = 1'b1;
        STG_WARN:           status_nx.irqf  = 1'b1;
        STG_FINAL:          status_nx.rtype = rst_ctl;
        default:            status_nx = status;
      endcase
    end
    if (sts_wr) status_nx = unpack_status(sts_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status  <= '0;
      halt    <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      status  <= status_nx;
      rst_req <= req_nx;
      if (final_hit) halt <= 1'b1;
    end
  end

  p_warn_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !status.warn && !sts_wr |=> status.warn);

  p_irqf_second_r3: assert property (@(posedge clk) disable iff (!rst_n)
    expire && status.warn && !status.irqf && !sts_wr |=> status.irqf);

  p_req_follows_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(expire));

  p_req_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  p_halt_sticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);

endmodule

// File: rtl/wdog_escalator.sv
module wdog_escalator #(
  parameter int unsigned BASE_LOG = 17,
  parameter int unsigned STEP_LOG = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] per_sel,
  input  logic [1:0] rst_ctl,
  input  logic       irq_en,
  input  logic       sts_wr,
  input  logic [3:0] sts_wdata,
  output logic       sts_warn,
  output logic       sts_irqf,
  output logic [1:0] rst_type,
  output logic       irq,
  output logic       rst_req
);
  import wdog_pkg::*;

  localparam int unsigned CW = BASE_LOG + 3 * STEP_LOG;

  logic          expire_w;
  logic          halt_w;
  logic [CW-1:0] cnt_w;
  wd_status_t    status_w;

  wdog_period_ctr #(.BASE_LOG(BASE_LOG), .STEP_LOG(STEP_LOG)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .halt    (halt_w),
    .per_sel (per_sel),
    .expire  (expire_w),
    .cnt     (cnt_w)
  );

  wdog_stage_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire    (expire_w),
    .rst_ctl   (rst_ctl),
    .sts_wr    (sts_wr),
    .sts_wdata (sts_wdata),
    .status    (status_w),
    .halt      (halt_w),
    .rst_req   (rst_req)
  );

  assign sts_warn = status_w.warn;
  assign sts_irqf = status_w.irqf;
  assign rst_type = status_w.rtype;
  assign irq      = status_w.irqf & irq_en;

  p_type_latched_r4: assert property (@(posedge clk) disable iff (!rst_n)
    expire_w && sts_warn && sts_irqf && !sts_wr |=> rst_type == $past(rst_ctl));

  p_no_expire_after_final_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !expire_w);

  p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> sts_irqf);

endmodule

// File: tb/wdog_escalator_tb_top.sv
module wdog_escalator_tb_top;

  localparam int BASE = 3;
  localparam int STEP = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] per_sel = 2'd0;
  logic [1:0] rst_ctl = 2'd0;
  logic       irq_en = 1'b0;
  logic       sts_wr = 1'b0;
  logic [3:0] sts_wdata = 4'd0;
  logic       sts_warn, sts_irqf, irq, rst_req;
  logic [1:0] rst_type;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  wdog_escalator #(.BASE_LOG(BASE), .STEP_LOG(STEP)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .per_sel(per_sel),
    .rst_ctl(rst_ctl), .irq_en(irq_en), .sts_wr(sts_wr),
    .sts_wdata(sts_wdata), .sts_warn(sts_warn), .sts_irqf(sts_irqf),
    .rst_type(rst_type), .irq(irq), .rst_req(rst_req)
  );

  // Reference model: counts ticks as an integer, flags as bits
  int m_cnt = 0;
  bit m_warn = 0, m_irqf = 0, m_halt = 0, m_req = 0;
  bit [1:0] m_rt = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_warn = 0; m_irqf = 0; m_halt = 0; m_req = 0; m_rt = 0;
    end else begin
      int lim;
      bit ex;
      bit nw, ni, nh, nr;
      bit [1:0] nt;
      int nc;
      lim = 1 << (BASE + STEP * per_sel);
      ex = tick && !m_halt && (m_cnt + 1 >= lim);
      nw = m_warn; ni = m_irqf; nt = m_rt; nh = m_halt; nc = m_cnt;
      nr = ex && m_warn && m_irqf && (rst_ctl != 0);
      if (ex) begin
        nc = 0;
        if (m_warn && m_irqf) begin nh = 1; nt = rst_ctl; end
        else if (!m_warn) nw = 1;
        else ni = 1;
      end else if (tick && !m_halt) nc = m_cnt + 1;
      if (sts_wr) begin nw = sts_wdata[3]; ni = sts_wdata[2]; nt = sts_wdata[1:0]; end
      m_cnt = nc; m_warn = nw; m_irqf = ni; m_rt = nt; m_halt = nh; m_req = nr;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Continuous comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R2 warn", sts_warn, m_warn);
      chk("R3 irqf", sts_irqf, m_irqf);
      chk("R4 rst_type", rst_type, m_rt);
      chk("R5 rst_req", rst_req, m_req);
      chk("R6 irq", irq, m_irqf & irq_en);
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; sts_wr = 0; tick = 0;
    @(negedge clk);
    chk("R1 warn", sts_warn, 0); chk("R1 irqf", sts_irqf, 0);
    chk("R1 rtype", rst_type, 0); chk("R1 irq", irq, 0); chk("R1 req", rst_req, 0);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    wait (cycles > 150000);
    bad++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", cycles, 150000);
    summary();
  end

  initial begin
    int pulses;
    // Full escalation with system reset kind, period 8
    do_reset();
    per_sel = 0; rst_ctl = 2'b11; irq_en = 1; tick = 1;
    wait_cyc(7);
    chk("R8 warn before period", sts_warn, 0);
    wait_cyc(1);
    chk("R8 warn at period", sts_warn, 1);
    chk("R2 warn set", sts_warn, 1);
    wait_cyc(8);
    chk("R3 irqf set", sts_irqf, 1);
    chk("R6 irq level", irq, 1);
    irq_en = 0; wait_cyc(1);
    chk("R6 irq masked", irq, 0);
    irq_en = 1;
    wait_cyc(6);
    chk("R5 no early req", rst_req, 0);
    wait_cyc(1);
    chk("R5 req pulse", rst_req, 1);
    chk("R4 type latched", rst_type, 3);
    wait_cyc(1);
    chk("R5 req single", rst_req, 0);
    pulses = 0;
    sts_wr = 1; sts_wdata = 4'b1100; wait_cyc(1); sts_wr = 0;
    for (int i = 0; i < 40; i++) begin wait_cyc(1); pulses += rst_req; end
    chk("R7 halted no pulse", pulses, 0);
    chk("R7 flags held", rst_type, 0);

    // Reset kind none: no pulse, still halts
    do_reset();
    rst_ctl = 2'b00; rst_type_dummy();
    tick = 1; pulses = 0;
    for (int i = 0; i < 60; i++) begin wait_cyc(1); pulses += rst_req; end
    chk("R5 none no pulse", pulses, 0);
    chk("R4 type none", rst_type, 0);

    // Tick gating and status writes as kicks
    do_reset();
    per_sel = 1; rst_ctl = 2'b01;
    for (int i = 0; i < 200; i++) begin
      tick = (i % 3 == 0);
      sts_wr = (i % 50 == 49); sts_wdata = 4'b0000;
      wait_cyc(1);
    end
    sts_wr = 0;
    chk("R9 kicked no irqf", sts_irqf, 0);

    // Write field positions
    sts_wr = 1; sts_wdata = 4'b1010; tick = 0; wait_cyc(1); sts_wr = 0;
    chk("R9 warn bit3", sts_warn, 1); chk("R9 irqf bit2", sts_irqf, 0);
    chk("R9 rtype bits", rst_type, 2);

    // Lowering the period past the count
    do_reset();
    per_sel = 2; tick = 1; wait_cyc(20);
    per_sel = 0; wait_cyc(1);
    chk("R10 early expiry", sts_warn, 1);

    // Random traffic checked by the model
    do_reset();
    for (int i = 0; i < 30000; i++) begin
      tick = ($urandom % 4) != 0;
      per_sel = ($urandom % 8 == 0) ? 2'($urandom) : 2'($urandom % 2);
      rst_ctl = 2'($urandom);
      irq_en = 1'($urandom);
      sts_wr = ($urandom % 60) == 0;
      sts_wdata = 4'($urandom);
      if ($urandom % 3000 == 0) begin
        rst_n = 0; wait_cyc(1); rst_n = 1;
      end
      wait_cyc(1);
    end
    summary();
  end

  task automatic rst_type_dummy();
    chk("R1 rtype after reset", rst_type, 0);
  endtask

endmodule